// File: doc/BRIEF.md
# SD Command Line Controller

This block issues one command frame on the single-wire command line of an SD or MMC card and, when the command asks for one, collects the card's answer. Software first writes a 32-bit argument word. It then writes a command word that carries the command index, a 2-bit answer type and a go bit. The controller does the rest. It frames the command, appends its CRC7 and shifts it out, one bit per card-clock period. It then listens for a start bit, shifts in either a 48-bit or a 136-bit answer, checks the answer CRC where the type asks for it, and records the result as sticky flags.

The card clock is a strobe, `cclk_tick`, produced by dividing the system clock by `DIV`. The controller drives the line and samples it only on cycles where the strobe is high. Register writes use a plain one-cycle write port with no back-pressure. Status and the four answer words are always visible on output ports. A sticky flag stays set until software writes a 1 to its position in the clear register.

Top module: `sdcmd_host`

## Requirements
- R1: Writing address 1 with bit 12 set while idle sends a 48-bit frame, MSB first, one bit per `cclk_tick`. The frame is: a 0 start bit, a 1 direction bit, index bits 5:0 of the written word, the 32-bit argument word (address 0), the CRC7 (x^7+x^3+1, zero seed) of those 40 bits, and a 1 end bit. The first bit driven while `cmd_oe` rises is 0.
- R2: Answer type is in bits 9:8 of the command word. With type 00 (no answer), status bit 7 is set when the end bit completes, no other flag is set, and `cmd_oe` is released.
- R3: With type 01 (short, CRC checked), a 48-bit answer whose CRC7 over its first 40 bits matches sets status bit 6. Answer bits 39:8 appear on `rsp_w0`.
- R4: With type 01, a CRC mismatch sets status bit 0 and leaves status bit 6 clear.
- R5: With type 10 (short, no CRC check), status bit 6 is set even when the answer CRC is wrong.
- R6: With type 11 (long), a 136-bit answer fills the words as follows: frame bits 127:96 go to `rsp_w0`, 95:64 to `rsp_w1`, 63:32 to `rsp_w2`, and bits 31:1 followed by a 0 to `rsp_w3`. The CRC7 covers frame bits 127:8 and is compared with bits 7:1. A match sets bit 6; a mismatch sets bit 0.
- R7: The line is sampled for a start bit on the 64 strobes that follow the strobe releasing it. A start bit on the 64th sample is accepted. With no start bit by then, status bit 2 is set.
- R8: A short answer leaves `rsp_w1` to `rsp_w3` unchanged.
- R9: Writing address 2 clears each sticky status bit (0, 2, 6, 7) whose position is 1 in the written data. Other bits are untouched.
- R10: Status bit 13 is 1 from the cycle after the start write until the command completes. `cmd_oe` is high only while the frame is being sent.
- R11: Writing address 1 with bit 12 clear while a command runs abandons it at once. The line is released, the controller returns to idle, no flag is set, and the next command runs normally.
- R12: After reset all status bits are 0 and `cmd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 argument, 1 command word, 2 flag clear |
| wr_data | input | 32 | Write data |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cclk_tick | output | 1 | One-cycle card-clock strobe |
| stat | output | 16 | Status: 0 CRC fail, 2 timeout, 6 answer ok, 7 sent, 13 busy |
| rsp_w0 | output | 32 | Answer word 0 |
| rsp_w1 | output | 32 | Answer word 1 |
| rsp_w2 | output | 32 | Answer word 2 |
| rsp_w3 | output | 32 | Answer word 3 |

## Verification
Two cases are hard to reach from the ports. The first is the edge of the answer window, where a start bit on the last sample counts but one strobe later it does not. The second is abandoning a frame halfway through its bits. The bench's card model counts strobes from the end bit it observed and starts its answer after a programmable gap, which puts the start bit exactly on sample 64 or sample 65. For the abort case, the bench issues a command with no expected frame queued, waits a fixed number of strobes, and then clears the go bit. The card model drops the partial frame, and the next command shows that the controller recovered.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_CHECK} sdc_state_e;
  typedef enum logic [1:0] {RT_NONE = 2'b00, RT_SHORT_CRC = 2'b01,
                            RT_SHORT_RAW = 2'b10, RT_LONG = 2'b11} rtype_e;
  localparam logic [1:0] A_ARG = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_CLR = 2'd2;
  localparam int CW_GO   = 12;
  localparam int FL_CRC  = 0;
  localparam int FL_TMO  = 2;
  localparam int FL_REND = 6;
  localparam int FL_SENT = 7;
  localparam int FL_ACT  = 13;
  localparam int STAT_W  = 16;
endpackage

// File: rtl/sdcmd_tick.sv
module sdcmd_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
  assign tick = (cnt == LAST);
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
  parameter logic [6:0] POLY = 7'h09
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  logic fb;
  assign fb = din ^ crc[6];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= '0;
    else if (en)       crc <= {crc[5:0], 1'b0} ^ (fb ? POLY : 7'h00);
  end
endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
  import sdcmd_pkg::*;
#(
  parameter int DIV = 4,
  parameter int TMO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              cclk_tick,
  output logic [STAT_W-1:0] stat,
  output logic [31:0]       rsp_w0,
  output logic [31:0]       rsp_w1,
  output logic [31:0]       rsp_w2,
  output logic [31:0]       rsp_w3
);
  localparam int TCW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [TCW-1:0] TMO_LAST = TCW'(TMO - 1);
  localparam logic [5:0] TX_BODY = 6'd40;
  localparam logic [5:0] TX_END  = 6'd48;
  localparam logic [7:0] RX_SHORT_LAST = 8'd47;
  localparam logic [7:0] RX_LONG_LAST  = 8'd135;

  sdc_state_e state;
  rtype_e     rt_q;
  logic [31:0]    arg_q;
  logic [39:0]    tx_sh;
  logic [5:0]     txcnt;
  logic [127:0]   rx_sh;
  logic [7:0]     rxcnt;
  logic [TCW-1:0] tcnt;
  logic fl_crc, fl_tmo, fl_rend, fl_sent;
  logic tick, wr_arg, wr_cmd, wr_clr, start, abort;
  logic [6:0] tx_crc, rx_crc;
  logic tx_bit, txc_en, rxc_en, rx_in_rng, crc_ok;
  logic [7:0] rx_idx, rx_last;
  logic set_sent, set_tmo, set_rend, set_crc;

  sdcmd_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));
  assign cclk_tick = tick;

  assign wr_arg = wr_en && (wr_addr == A_ARG);
  assign wr_cmd = wr_en && (wr_addr == A_CMD);
  assign wr_clr = wr_en && (wr_addr == A_CLR);
  assign start  = wr_cmd && wr_data[CW_GO] && (state == ST_IDLE);
  assign abort  = wr_cmd && !wr_data[CW_GO] && (state != ST_IDLE);

  // Transmit bit selection: body from shifter, then CRC, then end bit.
  always_comb begin
    if (txcnt < TX_BODY)    tx_bit = tx_sh[39];
    else if (txcnt < 6'd47) tx_bit = tx_crc[3'd6 - txcnt[2:0]];
    else                    tx_bit = 1'b1;
  end
  assign txc_en = tick && (state == ST_SEND) && (txcnt < TX_BODY);

  sdcmd_crc7 u_txcrc (.clk(clk), .rst_n(rst_n), .clr(start), .en(txc_en),
                      .din(tx_sh[39]), .crc(tx_crc));

  // Receive CRC window depends on answer length.
  assign rx_idx  = (state == ST_WAIT) ? 8'd0 : rxcnt;
  assign rx_last = (rt_q == RT_LONG) ? RX_LONG_LAST : RX_SHORT_LAST;
  assign rx_in_rng = (rt_q == RT_LONG) ? (rx_idx >= 8'd8 && rx_idx < 8'd128)
                                       : (rx_idx < 8'd40);
  assign rxc_en = tick && rx_in_rng &&
                  (((state == ST_WAIT) && !cmd_in) || (state == ST_RECV));

  sdcmd_crc7 u_rxcrc (.clk(clk), .rst_n(rst_n), .clr(start), .en(rxc_en),
                      .din(cmd_in), .crc(rx_crc));
  assign crc_ok = (rx_crc == rx_sh[7:1]);

  assign set_sent = !abort && tick && (state == ST_SEND) && (txcnt == TX_END) && (rt_q == RT_NONE);
  assign set_tmo  = !abort && tick && (state == ST_WAIT) && cmd_in && (tcnt == TMO_LAST);
  assign set_rend = !abort && (state == ST_CHECK) && ((rt_q == RT_SHORT_RAW) || crc_ok);
  assign set_crc  = !abort && (state == ST_CHECK) && (rt_q != RT_SHORT_RAW) && !crc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;  rt_q <= RT_NONE;  arg_q <= '0;
      tx_sh <= '0;  txcnt <= '0;  rx_sh <= '0;  rxcnt <= '0;  tcnt <= '0;
      cmd_oe <= 1'b0;  cmd_out <= 1'b1;
      rsp_w0 <= '0;  rsp_w1 <= '0;  rsp_w2 <= '0;  rsp_w3 <= '0;
    end else begin
      if (wr_arg) arg_q <= wr_data;
      if (abort) begin
        state <= ST_IDLE;  cmd_oe <= 1'b0;  cmd_out <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            state <= ST_SEND;
            rt_q  <= rtype_e'(wr_data[9:8]);
            tx_sh <= {2'b01, wr_data[5:0], arg_q};
            txcnt <= '0;
          end
          ST_SEND: if (tick) begin
            if (txcnt != TX_END) begin
              cmd_oe  <= 1'b1;
              cmd_out <= tx_bit;
              if (txcnt < TX_BODY) tx_sh <= {tx_sh[38:0], 1'b0};
              txcnt <= txcnt + 1'b1;
            end else begin
              cmd_oe  <= 1'b0;
              cmd_out <= 1'b1;
              tcnt    <= '0;
              state   <= (rt_q == RT_NONE) ? ST_IDLE : ST_WAIT;
            end
          end
          ST_WAIT: if (tick) begin
            if (!cmd_in) begin
              state <= ST_RECV;
              rxcnt <= 8'd1;
              rx_sh <= {rx_sh[126:0], 1'b0};
            end else if (tcnt == TMO_LAST) begin
              state <= ST_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_RECV: if (tick) begin
            rx_sh <= {rx_sh[126:0], cmd_in};
            rxcnt <= rxcnt + 1'b1;
            if (rxcnt == rx_last) state <= ST_CHECK;
          end
          ST_CHECK: begin
            state <= ST_IDLE;
            if (rt_q == RT_LONG) begin
              rsp_w0 <= rx_sh[127:96];
              rsp_w1 <= rx_sh[95:64];
              rsp_w2 <= rx_sh[63:32];
              rsp_w3 <= {rx_sh[31:1], 1'b0};
            end else begin
              rsp_w0 <= rx_sh[39:8];
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Sticky flags: set wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_crc <= 1'b0;  fl_tmo <= 1'b0;  fl_rend <= 1'b0;  fl_sent <= 1'b0;
    end else begin
      fl_crc  <= (fl_crc  & ~(wr_clr & wr_data[FL_CRC]))  | set_crc;
      fl_tmo  <= (fl_tmo  & ~(wr_clr & wr_data[FL_TMO]))  | set_tmo;
      fl_rend <= (fl_rend & ~(wr_clr & wr_data[FL_REND])) | set_rend;
      fl_sent <= (fl_sent & ~(wr_clr & wr_data[FL_SENT])) | set_sent;
    end
  end

  always_comb begin
    stat          = '0;
    stat[FL_CRC]  = fl_crc;
    stat[FL_TMO]  = fl_tmo;
    stat[FL_REND] = fl_rend;
    stat[FL_SENT] = fl_sent;
    stat[FL_ACT]  = (state != ST_IDLE);
  end

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out);
  assert_oe_in_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (state == ST_SEND));
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_sent, set_tmo, set_rend, set_crc}));
  assert_clear_tmo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wr_data[FL_TMO] && !set_tmo) |=> !stat[FL_TMO]);
  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!stat[FL_ACT] && !cmd_oe));
  assert_short_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && rt_q != RT_LONG) |=> ($stable(rsp_w1) && $stable(rsp_w3)));
  assert_timeout_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_tmo |=> (stat[FL_TMO] && !stat[FL_ACT]));
endmodule

// File: tb/tb_sdcmd_host.sv
module tb_sdcmd_host;
  localparam int DIV = 4;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmd_in = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cmd_out, cmd_oe, cclk_tick;
  logic [15:0] stat;
  logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;

  sdcmd_host #(.DIV(DIV), .TMO(64)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cclk_tick(cclk_tick),
    .stat(stat), .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [135:0] v, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st, input logic bad_crc);
    logic [39:0] h;
    logic [6:0] c;
    h = {2'b00, idx, st};
    c = crc7({96'b0, h}, 40) ^ {6'b0, bad_crc};
    return {88'b0, h, c, 1'b1};
  endfunction

  function automatic logic [135:0] long_rsp(input logic [119:0] body, input logic bad_crc);
    logic [6:0] c;
    c = crc7({16'b0, body}, 120) ^ {6'b0, bad_crc};
    return {2'b00, 6'h3F, body, c, 1'b1};
  endfunction

  // Scoreboard queue of expected command frames and card model state.
  logic [47:0] exp_q[$];
  logic [135:0] rsp_vec = '0;
  int rsp_len = 0, rsp_gap = 0;
  int ccnt = 0, cd = 0, ri = 0;
  bit sending = 0;
  logic [47:0] cap = '0;

  always @(negedge clk) begin
    if (rst_n && cclk_tick) begin
      if (sending) begin
        if (ri < rsp_len) begin cmd_in = rsp_vec[rsp_len-1-ri]; ri++; end
        else begin cmd_in = 1'b1; sending = 0; end
      end else if (cd > 0) begin
        cd--;
        if (cd == 0) begin sending = 1; cmd_in = rsp_vec[rsp_len-1]; ri = 1; end
      end
      if (cmd_oe) begin
        cap = {cap[46:0], cmd_out};
        ccnt++;
        if (ccnt == 48) begin
          ccnt = 0;
          if (exp_q.size() == 0) chk("R1 unexpected frame", 64'(cap), 64'hDEAD);
          else chk("R1 frame", 64'(cap), 64'(exp_q.pop_front()));
          cd = rsp_gap;
        end
      end else begin
        ccnt = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] rt,
                     input int gap, input logic [135:0] vec, input int len);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    exp_q.push_back({h, crc7({96'b0, h}, 40), 1'b1});
    rsp_vec = vec; rsp_len = len; rsp_gap = gap;
    wr(2'd0, arg);
    wr(2'd1, {19'b0, 1'b1, 2'b00, rt, 2'b00, idx});
    chk("R10 busy after start", 64'(stat[13]), 64'd1);
    while (stat[13]) @(negedge clk);
    while (sending || cd > 0) @(negedge clk);
    repeat (2 * DIV) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [119:0] body;
    logic [6:0] bc;
    body = 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32;
    bc = crc7({16'b0, body}, 120);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset status", 64'(stat), 64'h0);
    chk("R12 reset oe", 64'(cmd_oe), 64'h0);

    run(6'd0, 32'h0, 2'b00, 0, '0, 0);
    chk("R2 sent flag only", 64'(stat), 64'h0080);
    chk("R2 line released", 64'(cmd_oe), 64'h0);
    wr(2'd2, 32'h0080);
    chk("R9 clear sent", 64'(stat), 64'h0);

    run(6'd17, 32'h1234_5678, 2'b01, 5, short_rsp(6'd17, 32'hA5C3_0F11, 1'b0), 48);
    chk("R3 answer ok flag", 64'(stat), 64'h0040);
    chk("R3 word0", 64'(rsp_w0), 64'hA5C3_0F11);
    wr(2'd2, 32'hFFFF);

    run(6'd2, 32'h0, 2'b11, 3, long_rsp(body, 1'b0), 136);
    chk("R6 long ok flag", 64'(stat), 64'h0040);
    chk("R6 word0", 64'(rsp_w0), 64'(body[119:88]));
    chk("R6 word1", 64'(rsp_w1), 64'(body[87:56]));
    chk("R6 word2", 64'(rsp_w2), 64'(body[55:24]));
    chk("R6 word3", 64'(rsp_w3), 64'({body[23:0], bc, 1'b0}));
    wr(2'd2, 32'hFFFF);

    run(6'd13, 32'h0000_0001, 2'b01, 2, short_rsp(6'd13, 32'h0000_0900, 1'b0), 48);
    chk("R8 word0 short", 64'(rsp_w0), 64'h900);
    chk("R8 word1 kept", 64'(rsp_w1), 64'(body[87:56]));
    chk("R8 word3 kept", 64'(rsp_w3), 64'({body[23:0], bc, 1'b0}));
    wr(2'd2, 32'hFFFF);

    run(6'd17, 32'hCAFE_0001, 2'b01, 4, short_rsp(6'd17, 32'h1111_2222, 1'b1), 48);
    chk("R4 crc fail only", 64'(stat), 64'h0001);
    wr(2'd2, 32'hFFFF);

    run(6'd3, 32'hCAFE_0002, 2'b10, 4, short_rsp(6'd3, 32'h3333_4444, 1'b1), 48);
    chk("R5 unchecked ok", 64'(stat), 64'h0040);
    chk("R5 word0", 64'(rsp_w0), 64'h3333_4444);
    wr(2'd2, 32'hFFFF);

    run(6'd9, 32'h0, 2'b11, 3, long_rsp(body, 1'b1), 136);
    chk("R6 long crc fail", 64'(stat), 64'h0001);
    wr(2'd2, 32'hFFFF);

    run(6'd8, 32'h0000_01AA, 2'b01, 64, short_rsp(6'd8, 32'h0000_01AA, 1'b0), 48);
    chk("R7 start on last sample", 64'(stat), 64'h0040);
    wr(2'd2, 32'hFFFF);
    run(6'd8, 32'h0000_01AB, 2'b01, 65, short_rsp(6'd8, 32'h0000_01AB, 1'b0), 48);
    chk("R7 one sample late", 64'(stat), 64'h0004);
    wr(2'd2, 32'hFFFF);
    run(6'd55, 32'h0, 2'b01, 0, '0, 0);
    chk("R7 silent card", 64'(stat), 64'h0004);
    run(6'd55, 32'h5, 2'b01, 1, short_rsp(6'd55, 32'h0000_0120, 1'b0), 48);
    chk("R9 sticky combine", 64'(stat), 64'h0044);
    wr(2'd2, 32'h0004);
    chk("R9 partial clear", 64'(stat), 64'h0040);
    wr(2'd2, 32'hFFFF);

    rsp_gap = 0;
    wr(2'd0, 32'hFFFF_0000);
    wr(2'd1, {19'b0, 1'b1, 2'b00, 2'b01, 2'b00, 6'd5});
    repeat (10 * DIV) @(negedge clk);
    wr(2'd1, 32'h0);
    chk("R11 idle after abort", 64'(stat), 64'h0);
    chk("R11 line released", 64'(cmd_oe), 64'h0);
    repeat (100 * DIV) @(negedge clk);
    chk("R11 no late flag", 64'(stat), 64'h0);
    run(6'd12, 32'h0, 2'b00, 0, '0, 0);
    chk("R11 next command", 64'(stat), 64'h0080);
    chk("R1 all frames seen", 64'(exp_q.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule